// File: doc/BRIEF.md
# Configurable Lookup-Table Cluster with Pairwise Combining

This block models a programmable logic cell made of eight 4-input lookup tables. Each table holds a 16-entry truth table. The tables are loaded one at a time through a small synchronous configuration port. After loading, each table looks up its own 4-bit input vector and drives its own output bit without any clock delay.

The eight tables are grouped into four fixed neighbour pairs: tables 0 and 1, 2 and 3, 4 and 5, and 6 and 7. Each pair has one select input and one 2-bit mode field. In the split mode the two tables work on their own. In the multiplexed mode the select input chooses one of the pair's two results, and that choice replaces the even-numbered output. The 5-input mode uses the same datapath, with two differences: both tables are expected to see the same four inputs, and the select input acts as the fifth input. A per-pair flag shows when a pair in 5-input mode has two input vectors that disagree. Each pair picks its mode on its own, so 4-input and 5-input functions can be mixed freely across the cell.

Top module: `lut_cluster`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight truth tables are cleared to zero. From the next cycle, every `lut_out` bit reads 0, whatever the inputs are.
- R2: When `cfg_we` is high at a rising edge, table number `cfg_addr` (0 to 7) is loaded with `cfg_data`. The new contents show at the outputs from that edge on. No other table changes.
- R3: A table's lookup result is bit `v` of its truth table. Here `v` is the table's 4-bit input slice `lut_in[4*i+3:4*i]`, read as an unsigned index with bit 0 as the least significant bit.
- R4: Pair `p` has mode field `pair_mode[2p+1:2p]` (00 = split, 01 = multiplexed, 10 = 5-input, 11 = split). In split mode, `lut_out[2p]` is the even table's result and `pair_sel[p]` has no effect.
- R5: In every mode, the odd output `lut_out[2p+1]` is the odd table's own lookup result.
- R6: `f5_conflict[p]` is 1 exactly when pair `p` is in mode 10 and its two 4-bit input slices differ.
- R7: In modes 01 and 10, `lut_out[2p]` equals the even table's result when `pair_sel[p]` is 0. It equals the odd table's result when `pair_sel[p]` is 1.
- R8: The four pairs are independent. Any mix of modes gives, for each pair, the result its own mode defines.
- R9: While `cfg_we` is low, `cfg_addr` and `cfg_data` have no effect on any table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset; clears all tables |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Index of the table to write |
| cfg_data | input | 16 | Truth table to store |
| pair_mode | input | 8 | Two mode bits per pair; pair p uses bits 2p+1:2p |
| pair_sel | input | 4 | Select / fifth input, one bit per pair |
| lut_in | input | 32 | Four input bits per table; table i uses bits 4i+3:4i |
| lut_out | output | 8 | One output bit per table |
| f5_conflict | output | 4 | Per-pair flag: 5-input mode with mismatched inputs |

## Verification
The only state is the truth-table store. A wrong stored bit shows up only when that table's input vector points at the bit, either directly or through a pair's multiplexer. So the bench sweeps the input vectors at random every cycle and compares all outputs against a behavioural model, starting in the cycle after each write. A write to the wrong index, a missing reset clear, or a write leaking while the strobe is low is therefore seen within a few cycles of random inputs. A mistake in mode decoding, multiplexer polarity or the conflict flag is combinational and shows up in the same cycle the stimulus is applied.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;
    localparam int NUM_LUT  = 8;
    localparam int LUT_IN   = 4;
    localparam int TT_W     = 1 << LUT_IN;
    localparam int NUM_PAIR = NUM_LUT / 2;
    localparam int ADDR_W   = $clog2(NUM_LUT);

    typedef enum logic [1:0] {
        PM_SPLIT = 2'b00,
        PM_MUX   = 2'b01,
        PM_FIVE  = 2'b10,
        PM_SPARE = 2'b11
    } pair_mode_e;

    typedef struct packed {
        logic even_res;
        logic odd_res;
    } pair_res_t;

    function automatic logic mode_joins(input pair_mode_e m);
        return (m == PM_MUX) || (m == PM_FIVE);
    endfunction
endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store #(
    parameter int NUM_LUT = lut_cluster_pkg::NUM_LUT,
    parameter int TT_W    = lut_cluster_pkg::TT_W,
    localparam int ADDR_W = $clog2(NUM_LUT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [TT_W-1:0]         data,
    output logic [NUM_LUT*TT_W-1:0] tables
);
    logic [TT_W-1:0] tt_q [NUM_LUT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LUT; i++) tt_q[i] <= '0;
        end else if (we) begin
            tt_q[addr] <= data;
        end
    end

    generate
        for (genvar g = 0; g < NUM_LUT; g++) begin : g_flat
            assign tables[g*TT_W +: TT_W] = tt_q[g];
        end
    endgenerate

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> tt_q[$past(addr)] == $past(data));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(tables));
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
    parameter int IN_W = lut_cluster_pkg::LUT_IN,
    localparam int TT_W = 1 << IN_W
) (
    input  logic [TT_W-1:0] tt,
    input  logic [IN_W-1:0] idx,
    output logic            y
);
    assign y = tt[idx];
endmodule

// File: rtl/lut_pair.sv
module lut_pair
    import lut_cluster_pkg::*;
#(
    parameter int IN_W = LUT_IN,
    localparam int TT_W = 1 << IN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TT_W-1:0] tt_even,
    input  logic [TT_W-1:0] tt_odd,
    input  logic [IN_W-1:0] in_even,
    input  logic [IN_W-1:0] in_odd,
    input  pair_mode_e      mode,
    input  logic            sel,
    output logic            out_even,
    output logic            out_odd,
    output logic            conflict
);
    pair_res_t raw;

    lut_cell #(.IN_W(IN_W)) u_even (.tt(tt_even), .idx(in_even), .y(raw.even_res));
    lut_cell #(.IN_W(IN_W)) u_odd  (.tt(tt_odd),  .idx(in_odd),  .y(raw.odd_res));

    always_comb begin
        out_even = raw.even_res;
        if (mode_joins(mode) && sel) out_even = raw.odd_res;
    end

    assign out_odd  = raw.odd_res;
    assign conflict = (mode == PM_FIVE) && (in_even != in_odd);

    assert_split_ignores_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SPLIT || mode == PM_SPARE) |-> out_even == raw.even_res);

    assert_join_picks_odd_R7: assert property (@(posedge clk) disable iff (rst)
        ((mode == PM_MUX || mode == PM_FIVE) && sel) |-> out_even == raw.odd_res);

    assert_flag_only_five_R6: assert property (@(posedge clk) disable iff (rst)
        conflict |-> mode == PM_FIVE);
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lut_cluster_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [TT_W-1:0]           cfg_data,
    input  logic [2*NUM_PAIR-1:0]     pair_mode,
    input  logic [NUM_PAIR-1:0]       pair_sel,
    input  logic [NUM_LUT*LUT_IN-1:0] lut_in,
    output logic [NUM_LUT-1:0]        lut_out,
    output logic [NUM_PAIR-1:0]       f5_conflict
);
    logic [NUM_LUT*TT_W-1:0] tables;

    lut_cfg_store #(.NUM_LUT(NUM_LUT), .TT_W(TT_W)) u_store (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .data(cfg_data), .tables(tables)
    );

    generate
        for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
            lut_pair #(.IN_W(LUT_IN)) u_pair (
                .clk(clk),
                .rst(rst),
                .tt_even(tables[(2*p)*TT_W +: TT_W]),
                .tt_odd(tables[(2*p+1)*TT_W +: TT_W]),
                .in_even(lut_in[(2*p)*LUT_IN +: LUT_IN]),
                .in_odd(lut_in[(2*p+1)*LUT_IN +: LUT_IN]),
                .mode(pair_mode_e'(pair_mode[2*p +: 2])),
                .sel(pair_sel[p]),
                .out_even(lut_out[2*p]),
                .out_odd(lut_out[2*p+1]),
                .conflict(f5_conflict[p])
            );
        end
    endgenerate
endmodule

// File: tb/sim_lut_cluster.sv
`timescale 1ns/1ps
module sim_lut_cluster;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [7:0]  pair_mode = '0;
    logic [3:0]  pair_sel = '0;
    logic [31:0] lut_in = '0;
    logic [7:0]  lut_out;
    logic [3:0]  f5_conflict;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int ref_tt [8];

    always #4 clk = ~clk;

    lut_cluster u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .pair_mode(pair_mode), .pair_sel(pair_sel),
        .lut_in(lut_in), .lut_out(lut_out), .f5_conflict(f5_conflict)
    );

    function automatic int look(int i);
        int v = (lut_in >> (4*i)) & 15;
        return (ref_tt[i] >> v) & 1;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] exp_even_mask, exp_out;
        logic [3:0] exp_flag;
        exp_out = '0;
        exp_flag = '0;
        exp_even_mask = 8'h55;
        for (int p = 0; p < 4; p++) begin
            int m = (pair_mode >> (2*p)) & 3;
            int ev = look(2*p);
            int od = look(2*p+1);
            int e = ev;
            if ((m == 1 || m == 2) && pair_sel[p]) e = od;
            exp_out[2*p]   = e[0];
            exp_out[2*p+1] = od[0];
            exp_flag[p] = (m == 2) && (((lut_in >> (8*p)) & 15) != ((lut_in >> (8*p+4)) & 15));
        end
        total++;
        if ((lut_out & exp_even_mask) !== (exp_out & exp_even_mask)) begin
            bad++;
            $display("FAIL %s even outputs: actual=%b expected=%b", tag,
                     lut_out & exp_even_mask, exp_out & exp_even_mask);
        end
        total++;
        if ((lut_out & ~exp_even_mask) !== (exp_out & ~exp_even_mask)) begin
            bad++;
            $display("FAIL R5 odd outputs (%s): actual=%b expected=%b", tag,
                     lut_out & ~exp_even_mask, exp_out & ~exp_even_mask);
        end
        total++;
        if (f5_conflict !== exp_flag) begin
            bad++;
            $display("FAIL R6 conflict flag (%s): actual=%b expected=%b", tag,
                     f5_conflict, exp_flag);
        end
    endtask

    task automatic cycle(input string tag);
        @(negedge clk);
        compare(tag);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 8; i++) ref_tt[i] = 0;
        end else if (cfg_we) begin
            ref_tt[cfg_addr] = int'(cfg_data);
        end
        #1;
    endtask

    task automatic rand_inputs(input bit five_bias);
        lut_in = $urandom;
        pair_sel = 4'($urandom);
        if (five_bias) begin
            for (int p = 0; p < 4; p++)
                if ($urandom % 2 == 0) lut_in[8*p+4 +: 4] = lut_in[8*p +: 4];
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < 8; i++) begin
            cfg_we = 1'b1;
            cfg_addr = 3'(i);
            cfg_data = 16'($urandom);
            rand_inputs(0);
            cycle("R2 load");
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ref_tt[i] = 0;
        void'($urandom(32'h5eed));
        // R1: reset clears the tables
        rst = 1'b1;
        @(posedge clk); #1;
        for (int k = 0; k < 3; k++) begin rand_inputs(0); cycle("R1 reset"); end
        rst = 1'b0;

        // R2: loading each table, then using it
        load_all();
        for (int k = 0; k < 10; k++) begin rand_inputs(0); cycle("R2 after load"); end

        // R3 / R4: split mode, select toggling must not matter
        pair_mode = 8'h00;
        for (int k = 0; k < 40; k++) begin rand_inputs(0); cycle("R3 R4 split"); end

        // R7: multiplexed mode
        pair_mode = 8'h55;
        for (int k = 0; k < 40; k++) begin rand_inputs(0); cycle("R7 mux"); end

        // R6 / R7: 5-input mode with matched and mismatched inputs
        pair_mode = 8'hAA;
        for (int k = 0; k < 40; k++) begin rand_inputs(1); cycle("R6 R7 five"); end

        // R4: spare code behaves as split
        pair_mode = 8'hFF;
        for (int k = 0; k < 20; k++) begin rand_inputs(0); cycle("R4 spare"); end

        // R8: mixed modes per pair, with rewrites in between
        for (int k = 0; k < 60; k++) begin
            pair_mode = 8'($urandom);
            rand_inputs(1);
            cfg_we = ($urandom % 4 == 0);
            cfg_addr = 3'($urandom);
            cfg_data = 16'($urandom);
            cycle("R8 mixed");
        end
        cfg_we = 1'b0;

        // R9: strobe low, address and data wiggle
        pair_mode = 8'h00;
        for (int k = 0; k < 40; k++) begin
            cfg_addr = 3'($urandom);
            cfg_data = 16'($urandom);
            rand_inputs(0);
            cycle("R9 no write");
        end

        // R1: reset after loading clears again
        rst = 1'b1;
        cycle("R1 reset edge");
        for (int k = 0; k < 5; k++) begin rand_inputs(0); cycle("R1 cleared"); end
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin pair_mode = 8'($urandom); rand_inputs(0); cycle("R1 stays clear"); end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule